// File: doc/BRIEF.md
# SPI Fault Diagnostic Register

This block collects digital fault indications from four low-side switch channels, one over-temperature and one open-load indication per channel, into eight sticky flags. Any set flag raises an interrupt request to a host processor. The host then runs an SPI frame to read the flags and see which fault occurred.

When chip select falls, the current flags are loaded into an 8-bit shift register. Each rising SCK edge presents the next bit on SO, most significant bit first. Each falling SCK edge takes one bit from SI into the register. Because bits taken from SI come out of SO after the block's own eight bits, several blocks can be chained in cascade and read in one continuous frame. All SPI pins are synchronised into the system clock, which must run at least four times the SCK rate.

A separate active-low flag clear input (`clr_n`) clears the flags and removes the output-enable while it is low. It leaves the shift register untouched. The shift register is only emptied when a later frame starts with no faults present.

Top module: `fault_diag_spi`

## Requirements
- R1: The flag word is 8 bits. Bits 3..0 are over-temperature for channels D, C, B, A and bits 7..4 are open-load for channels D, C, B, A. A frame returns this word on SO starting with bit 7.
- R2: A flag sets when its fault input is high for a system clock. It stays set after the input returns low, until `clr_n` is low.
- R3: `irq` is high exactly when at least one flag is set.
- R4: While `clr_n` is low, all flags read zero and `out_en` is low. The shift register contents are kept, so a frame in progress keeps shifting out its loaded data.
- R5: While `cs_n` is high, `so_oe` is low and `so` is 0. After `cs_n` falls, `so_oe` is high and `so` is 0 until the first rising SCK edge.
- R6: Each rising SCK edge in a frame puts the next bit on SO, most significant first.
- R7: SI is captured on each falling SCK edge. In a frame longer than 8 bits, SO carries the SI bits in order after the 8 flag bits (cascade).
- R8: After a clear, a frame started with no faults present returns all zeros.
- R9: A frame that starts with SCK high is ignored: it performs no load and no shift, and `so` stays 0. The next well-formed frame works normally.
- R10: A fault that sets its flag in the same cycle as the chip-select load is absent from that frame. It is kept and reported in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n | input | 1 | Active-low flag clear and output disable |
| ot_fault | input | 4 | Over-temperature indications, channels A..D at bits 0..3 |
| ol_fault | input | 4 | Open-load indications, channels A..D at bits 0..3 |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out (valid when so_oe is high) |
| so_oe | output | 1 | Output enable for the SO pad; low means three-state |
| irq | output | 1 | Fault interrupt request |
| out_en | output | 1 | Enable for the channel output drivers |

## Verification
The chip-select load and a new fault setting its flag can land on the same system clock edge. The load takes the flag value from before that edge. The bench reaches this collision by timing a fault pulse to the cycle in which the synchronised chip-select fall is acted on, counting the two synchroniser stages and the edge register. It then checks that the first frame reads zero, that `irq` is high, and that the following frame reports the fault. A second overlap is a flag clear arriving in the middle of a frame. There the bench checks that the remaining bits still carry the word that was loaded.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;

  // Frame tracking for the serial side.
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,  // chip select high, SO released
    FR_RUN  = 2'd1,  // well-formed frame, shifting enabled
    FR_BAD  = 2'd2   // frame began with SCK high, ignored until CS rises
  } frame_state_t;

  // Index of the over-temperature flag for channel ch.
  function automatic int ot_bit(input int ch);
    return ch;
  endfunction

  // Index of the open-load flag for channel ch, given the channel count.
  function automatic int ol_bit(input int ch, input int n_ch);
    return n_ch + ch;
  endfunction

endpackage

// File: rtl/fdiag_sync.sv
module fdiag_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fdiag_flags.sv
module fdiag_flags #(
  parameter int CH     = 4,
  localparam int FLAG_W = 2 * CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_s,     // synchronised clear, active low
  input  logic [CH-1:0]     ot_fault,
  input  logic [CH-1:0]     ol_fault,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic              out_en
);

  logic [FLAG_W-1:0] flags_q, flags_d, fault_vec;

  // Place each channel's indications at its bit positions.
  for (genvar c = 0; c < CH; c++) begin : g_map
    assign fault_vec[fdiag_pkg::ot_bit(c)]     = ot_fault[c];
    assign fault_vec[fdiag_pkg::ol_bit(c, CH)] = ol_fault[c];
  end

  always_comb begin
    if (!clr_s) flags_d = '0;
    else        flags_d = flags_q | fault_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags  = flags_q;
  assign irq    = |flags_q;
  assign out_en = clr_s;

endmodule

// File: rtl/fdiag_shift.sv
module fdiag_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_s,      // synchronised chip select (active low)
  input  logic         sck_s,
  input  logic         si_s,
  input  logic [W-1:0] load_val,
  output logic         so,
  output logic         so_oe
);
  import fdiag_pkg::*;

  logic         cs_d, sck_d;
  logic         cs_fall, cs_rise, sck_rise, sck_fall;
  frame_state_t st_q, st_d;
  logic [W-1:0] sr_q, sr_d;
  logic         so_q, so_d;

  assign cs_fall  =  cs_d & ~cs_s;
  assign cs_rise  = ~cs_d &  cs_s;
  assign sck_rise = ~sck_d &  sck_s;
  assign sck_fall =  sck_d & ~sck_s;

  // Next-state logic
  always_comb begin
    st_d = st_q;
    sr_d = sr_q;
    so_d = so_q;
    unique case (st_q)
      FR_IDLE: begin
        so_d = 1'b0;
        if (cs_fall) begin
          if (sck_s) begin
            st_d = FR_BAD;
          end else begin
            st_d = FR_RUN;
            sr_d = load_val;
          end
        end
      end
      FR_RUN: begin
        if (cs_rise) begin
          st_d = FR_IDLE;
          so_d = 1'b0;
        end else begin
          if (sck_rise) so_d = sr_q[W-1];
          if (sck_fall) sr_d = {sr_q[W-2:0], si_s};
        end
      end
      FR_BAD: begin
        so_d = 1'b0;
        if (cs_rise) st_d = FR_IDLE;
      end
      default: begin
        st_d = FR_IDLE;
        so_d = 1'b0;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
      st_q  <= FR_IDLE;
      sr_q  <= '0;
      so_q  <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
      st_q  <= st_d;
      sr_q  <= sr_d;
      so_q  <= so_d;
    end
  end

  assign so_oe = (st_q != FR_IDLE);
  assign so    = so_q & so_oe;

endmodule

// File: rtl/fault_diag_spi.sv
module fault_diag_spi #(
  parameter int CHANNELS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_n,
  input  logic [CHANNELS-1:0] ot_fault,
  input  logic [CHANNELS-1:0] ol_fault,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                si,
  output logic                so,
  output logic                so_oe,
  output logic                irq,
  output logic                out_en
);

  localparam int FLAG_W = 2 * CHANNELS;

  logic              rst_sync_n;
  logic [3:0]        pins_s;
  logic              clr_s, cs_s, sck_s, si_s;
  logic [FLAG_W-1:0] flags;

  // Reset asserts asynchronously and is released on a clock edge.
  fdiag_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  // Pin order {clr, cs, sck, si}; chip select rests high.
  fdiag_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n), .d({clr_n, cs_n, sck, si}), .q(pins_s)
  );

  assign {clr_s, cs_s, sck_s, si_s} = pins_s;

  fdiag_flags #(.CH(CHANNELS)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .clr_s(clr_s),
    .ot_fault(ot_fault), .ol_fault(ol_fault),
    .flags(flags), .irq(irq), .out_en(out_en)
  );

  fdiag_shift #(.W(FLAG_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n),
    .cs_s(cs_s), .sck_s(sck_s), .si_s(si_s),
    .load_val(flags), .so(so), .so_oe(so_oe)
  );

endmodule

// File: rtl/fdiag_checker.sv
module fdiag_checker #(
  parameter int CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_s,
  input logic [2*CH-1:0] flags,
  input logic [CH-1:0]   ot_fault,
  input logic [CH-1:0]   ol_fault,
  input logic            irq,
  input logic            so,
  input logic            so_oe
);

  // R4: a clear empties every flag on the next edge
  assert_clear_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> (flags == '0));

  // R2: without a clear, no set flag drops
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> ((flags & $past(flags)) == $past(flags)));

  // R3: an interrupt only starts after a fault input was seen
  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|{ot_fault, ol_fault}));

  // R5: SO is quiet whenever it is released
  assert_so_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !so_oe |-> !so);

  // R5: SO starts every frame low
  assert_so_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> !so);

endmodule

bind fault_diag_spi fdiag_checker #(.CH(CHANNELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .flags(flags),
  .ot_fault(ot_fault), .ol_fault(ol_fault),
  .irq(irq), .so(so), .so_oe(so_oe)
);

// File: tb/tb_fault_diag_spi.sv
module tb_fault_diag_spi;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;   // system clocks per SCK half period

  logic       clk, rst_n, clr_n, cs_n, sck, si;
  logic [3:0] ot_fault, ol_fault;
  logic       so, so_oe, irq, out_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  fault_diag_spi dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
    .ot_fault(ot_fault), .ol_fault(ol_fault),
    .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .irq(irq), .out_en(out_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_fault(input logic [3:0] ot, input logic [3:0] ol);
    ot_fault = ot; ol_fault = ol;
    wait_n(2);
    ot_fault = '0; ol_fault = '0;
    wait_n(3);
  endtask

  // Shift n bits with chip select already low. clr_n drops before bit clr_at.
  task automatic shift_bits(input int n, input logic [15:0] din, input int clr_at,
                            output logic [15:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      if (i == clr_at) clr_n = 1'b0;
      sck = 1'b1;
      wait_n(HALF);
      dout[n-1-i] = so;
      si = din[n-1-i];
      wait_n(3);
      sck = 1'b0;
      wait_n(HALF);
    end
  endtask

  task automatic frame(input int n, input logic [15:0] din, input int clr_at,
                       output logic [15:0] dout);
    cs_n = 1'b0;
    wait_n(HALF);
    check("R5 oe before first SCK", {31'd0, so_oe}, 32'd1);
    check("R5 so low before first SCK", {31'd0, so}, 32'd0);
    shift_bits(n, din, clr_at, dout);
    cs_n = 1'b1;
    wait_n(HALF);
    check("R5 released after frame", {30'd0, so_oe, so}, 32'd0);
    clr_n = 1'b1;
    wait_n(4);
  endtask

  task automatic do_clear;
    clr_n = 1'b0;
    wait_n(4);
    check("R4 irq cleared", {31'd0, irq}, 32'd0);
    check("R4 out_en low", {31'd0, out_en}, 32'd0);
    clr_n = 1'b1;
    wait_n(4);
    check("R4 out_en back", {31'd0, out_en}, 32'd1);
  endtask

  task automatic t_reset;
    check("R5 idle released", {30'd0, so_oe, so}, 32'd0);
    check("R3 irq idle", {31'd0, irq}, 32'd0);
    check("R4 out_en after reset", {31'd0, out_en}, 32'd1);
  endtask

  task automatic t_map;
    logic [15:0] d;
    pulse_fault(4'b0010, 4'b0100);        // OT channel B, OL channel C
    check("R3 irq on fault", {31'd0, irq}, 32'd1);
    frame(8, 16'h0000, -1, d);
    check("R1 R6 bit map", {24'd0, d[7:0]}, 32'h42);
    do_clear();
  endtask

  task automatic t_sticky;
    logic [15:0] d;
    pulse_fault(4'b1000, 4'b0001);        // OT D, OL A
    wait_n(10);
    check("R2 irq still set", {31'd0, irq}, 32'd1);
    frame(8, 16'h0000, -1, d);
    check("R2 flags kept", {24'd0, d[7:0]}, 32'h18);
    frame(8, 16'h0000, -1, d);
    check("R2 flags kept after read", {24'd0, d[7:0]}, 32'h18);
  endtask

  task automatic t_clear_mid;
    logic [15:0] d;
    // Flags currently 0x18; clear drops during bit 3.
    frame(8, 16'h0000, 3, d);
    check("R4 shift register kept across clear", {24'd0, d[7:0]}, 32'h18);
    check("R4 irq after clear", {31'd0, irq}, 32'd0);
    frame(8, 16'h0000, -1, d);
    check("R8 zero load after clear", {24'd0, d[7:0]}, 32'h00);
  endtask

  task automatic t_cascade;
    logic [15:0] d;
    pulse_fault(4'b0101, 4'b0000);
    frame(16, 16'hA5C3, -1, d);
    check("R7 cascade order", {16'd0, d}, {16'd0, 8'h05, 8'hA5});
    frame(12, 16'h0F3C, -1, d);
    check("R6 R7 partial cascade", {20'd0, d[11:0]}, {20'd0, 8'h05, 4'hF});
    do_clear();
  endtask

  task automatic t_bad_frame;
    logic [15:0] d;
    pulse_fault(4'b0000, 4'b1000);
    sck = 1'b1;
    wait_n(4);
    cs_n = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1;
      sck = 1'b0; wait_n(HALF);
      sck = 1'b1; wait_n(HALF);
      check("R9 so held low", {31'd0, so}, 32'd0);
    end
    sck = 1'b0;
    wait_n(HALF);
    cs_n = 1'b1;
    wait_n(HALF);
    si = 1'b0;
    frame(8, 16'h0000, -1, d);
    check("R9 recovery frame", {24'd0, d[7:0]}, 32'h80);
    do_clear();
  endtask

  task automatic t_collide;
    logic [15:0] d;
    cs_n = 1'b0;          // at a falling clock edge
    wait_n(2);            // two synchroniser stages
    ot_fault = 4'b0100;   // sets its flag on the load edge
    wait_n(1);
    ot_fault = '0;
    wait_n(HALF);
    shift_bits(8, 16'h0000, -1, d);
    cs_n = 1'b1;
    wait_n(HALF);
    check("R10 not in colliding frame", {24'd0, d[7:0]}, 32'h00);
    check("R10 irq raised", {31'd0, irq}, 32'd1);
    frame(8, 16'h0000, -1, d);
    check("R10 in next frame", {24'd0, d[7:0]}, 32'h04);
  endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    ot_fault = '0; ol_fault = '0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(6);
    t_reset();
    t_map();
    t_sticky();
    t_clear_mid();
    t_cascade();
    t_bad_frame();
    t_collide();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule